// File: doc/BRIEF.md
# Multi-Channel Prescaled PWM Generator

This block is a memory-mapped pulse-width modulator with a parameterised number of independent channels. A shared enable register holds one run bit per channel. Each channel has an edge register, with the counts at which the output enters and leaves its active phase, and a timing register, with the period count, two encoded output levels and a clock divider index. Every register can be written directly or through set, clear and toggle aliases, so software can start or stop one channel with a single write and no read-modify-write.

Each channel runs its own prescaler. The prescaler picks one of eight uneven divide ratios. A period counter wraps after the programmed count. An output stage drives the pad value and its output enable. New timing and edge values written while a channel runs are held in a shadow copy and only take effect at the next wrap, so a running waveform never shows a cut-short or stretched period. A stopped channel holds its counters at zero and shows its programmed idle level.

Top module: `pwm_bank`

## Requirements
- R1: After reset every register reads zero and every `pwm_oe` bit is low.
- R2: A direct write (address bits 3:2 = 0) stores the data, and a read returns the stored value. The timing register keeps only bits 22:0 and reads zero in bits 31:23. The enable register reads zero above bit NUM_CHANNELS-1. Any address outside the map reads zero.
- R3: Address bits 3:2 select the write operation on every register: 1 ORs the data in, 2 clears the bits set in the data, and 3 XORs the data in.
- R4: The enable register is at 0x000. Channel n's edge register is at 0x010 + 0x20*n and its timing register at 0x020 + 0x20*n. Enable bit n runs channel n only, and channels run independently.
- R5: The timing register's bits 15:0 hold the period count P. Once per prescaler tick the counter counts 0..P and wraps, giving P+1 ticks per period. The edge register's bits 15:0 hold the rise count A and bits 31:16 the fall count B. When the count reaches A the channel goes active. When it reaches B the channel goes inactive, and B wins if both match. When neither matches, the phase holds. With A < B the output is active exactly for counts A..B-1.
- R6: Timing register bits 17:16 give the active-phase level and bits 19:18 the inactive-phase level. Codes 0 and 1 release the pin (`pwm_oe` = 0, `pwm_out` = 0), 2 drives low and 3 drives high.
- R7: Timing register bits 22:20 select the tick divider: index 0..7 means one tick every 1, 2, 4, 8, 16, 64, 256 or 1024 clocks.
- R8: Timing and edge values written while a channel runs take effect only at the wrap that ends the current period.
- R9: While its enable bit is clear, a channel holds counter and prescaler at zero and outputs the inactive level currently held in its timing register. After the enable bit is set, the counter starts from zero in the first cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read strobe |
| pwm_out | output | NUM_CHANNELS | Output value per channel |
| pwm_oe | output | NUM_CHANNELS | Output enable per channel |

## Verification
The hardest situation to reach from the ports is a reprogramming that lands in the middle of a running period. Only the waveform after the wrap shows whether the shadow copy held. The bench handles this by driving the bus inside its per-cycle sampling loop, so both writes land at known counts before the wrap. It then compares every cycle against the old settings up to the wrap and against the new ones after it. The slowest divider ratios are also costly to reach. They are covered with a two-count period, so that every index is checked over full periods within a few thousand cycles.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

   localparam int CNT_W  = 16;
   localparam int PRE_W  = 10;
   localparam logic [31:0] TIMING_MASK = 32'h007F_FFFF;

   typedef enum logic [1:0] {
      OP_WRITE  = 2'd0,
      OP_SET    = 2'd1,
      OP_CLEAR  = 2'd2,
      OP_TOGGLE = 2'd3
   } wr_op_e;

   typedef struct packed {
      logic [8:0]       rsvd;
      logic [2:0]       div_sel;
      logic [1:0]       idle_lvl;
      logic [1:0]       busy_lvl;
      logic [CNT_W-1:0] span;
   } timing_t;

   typedef struct packed {
      logic [CNT_W-1:0] fall;
      logic [CNT_W-1:0] rise;
   } edges_t;

   function automatic logic [31:0] apply_op(wr_op_e op, logic [31:0] old_v, logic [31:0] wd);
      case (op)
         OP_SET:    return old_v | wd;
         OP_CLEAR:  return old_v & ~wd;
         OP_TOGGLE: return old_v ^ wd;
         default:   return wd;
      endcase
   endfunction

   // ratios 1,2,4,8,16 then 64,256,1024: exponent idx below 5, else 2*idx-4
   function automatic logic [PRE_W-1:0] div_limit(logic [2:0] idx);
      int sh;
      sh = (idx < 3'd5) ? int'(idx) : (2 * int'(idx) - 4);
      return PRE_W'((1 << sh) - 1);
   endfunction

   function automatic logic next_phase(logic [CNT_W-1:0] c, edges_t e, logic cur);
      if (c == e.fall) return 1'b0;
      if (c == e.rise) return 1'b1;
      return cur;
   endfunction

endpackage

// File: rtl/pwm_bank_regfile.sv
module pwm_bank_regfile
   import pwm_bank_pkg::*;
#(
   parameter int NUM_CHANNELS = 8,
   parameter int ADDR_W       = 12
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          bus_sel,
   input  logic                          bus_we,
   input  logic [ADDR_W-1:0]             bus_addr,
   input  logic [31:0]                   bus_wdata,
   output logic [31:0]                   bus_rdata,
   output logic [NUM_CHANNELS-1:0]       run_en,
   output logic [NUM_CHANNELS-1:0][31:0] edge_cfg,
   output logic [NUM_CHANNELS-1:0][31:0] time_cfg
);

   localparam int SLOT_W = ADDR_W - 4;

   logic [SLOT_W-1:0]       slot;
   wr_op_e                  op;
   logic                    wr;
   logic [NUM_CHANNELS-1:0] ctrl_q;
   logic [31:0]             ctrl_nxt;

   assign slot = bus_addr[ADDR_W-1:4];
   assign op   = wr_op_e'(bus_addr[3:2]);
   assign wr   = bus_sel & bus_we;

   assign ctrl_nxt = apply_op(op, {{(32-NUM_CHANNELS){1'b0}}, ctrl_q}, bus_wdata);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          ctrl_q <= '0;
      else if (wr && slot == '0)           ctrl_q <= ctrl_nxt[NUM_CHANNELS-1:0];
   end

   assign run_en = ctrl_q;

   for (genvar n = 0; n < NUM_CHANNELS; n++) begin : g_chan_regs
      localparam logic [SLOT_W-1:0] EDGE_SLOT = SLOT_W'(2 * n + 1);
      localparam logic [SLOT_W-1:0] TIME_SLOT = SLOT_W'(2 * n + 2);
      logic [31:0] edge_r;
      logic [31:0] time_r;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            edge_r <= '0;
            time_r <= '0;
         end else if (wr) begin
            if (slot == EDGE_SLOT) edge_r <= apply_op(op, edge_r, bus_wdata);
            if (slot == TIME_SLOT) time_r <= apply_op(op, time_r, bus_wdata) & TIMING_MASK;
         end
      end

      assign edge_cfg[n] = edge_r;
      assign time_cfg[n] = time_r;
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_we) begin
         if (slot == '0) bus_rdata = {{(32-NUM_CHANNELS){1'b0}}, ctrl_q};
         for (int n = 0; n < NUM_CHANNELS; n++) begin
            if (slot == SLOT_W'(2 * n + 1)) bus_rdata = edge_cfg[n];
            if (slot == SLOT_W'(2 * n + 2)) bus_rdata = time_cfg[n];
         end
      end
   end

   // R3: a set alias leaves every written bit at one
   p_set_alias_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && slot == '0 && op == OP_SET)
      |=> ((ctrl_q & $past(bus_wdata[NUM_CHANNELS-1:0])) == $past(bus_wdata[NUM_CHANNELS-1:0])));

   // R3: a clear alias leaves every written bit at zero
   p_clear_alias_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && slot == '0 && op == OP_CLEAR)
      |=> ((ctrl_q & $past(bus_wdata[NUM_CHANNELS-1:0])) == '0));

endmodule

// File: rtl/pwm_bank_prescaler.sv
module pwm_bank_prescaler
   import pwm_bank_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [2:0] div_sel,
   output logic       tick
);

   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] lim;

   assign lim  = div_limit(div_sel);
   assign tick = run && (pre_q == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pre_q <= '0;
      else if (!run)    pre_q <= '0;
      else if (tick)    pre_q <= '0;
      else              pre_q <= pre_q + 1'b1;
   end

   // R9: a stopped prescaler sits at zero
   p_pre_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (pre_q == '0));

endmodule

// File: rtl/pwm_bank_channel.sv
module pwm_bank_channel
   import pwm_bank_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        en,
   input  logic [31:0] edge_live,
   input  logic [31:0] time_live,
   output logic        pwm_out,
   output logic        pwm_oe
);

   timing_t          live_t;
   edges_t           live_e;
   timing_t          sh_t;
   edges_t           sh_e;
   logic [CNT_W-1:0] cnt_q;
   logic             phase_q;
   logic             tick;
   logic             wrap;
   logic [1:0]       lvl;

   assign live_t = timing_t'(time_live);
   assign live_e = edges_t'(edge_live);

   pwm_bank_prescaler u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (en),
      .div_sel (sh_t.div_sel),
      .tick    (tick)
   );

   assign wrap = (cnt_q == sh_t.span);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         phase_q <= 1'b0;
         sh_t    <= '0;
         sh_e    <= '0;
      end else if (!en) begin
         cnt_q   <= '0;
         sh_t    <= live_t;
         sh_e    <= live_e;
         phase_q <= next_phase('0, live_e, 1'b0);
      end else if (tick) begin
         if (wrap) begin
            cnt_q   <= '0;
            sh_t    <= live_t;
            sh_e    <= live_e;
            phase_q <= next_phase('0, live_e, phase_q);
         end else begin
            cnt_q   <= cnt_q + 1'b1;
            phase_q <= next_phase(cnt_q + 1'b1, sh_e, phase_q);
         end
      end
   end

   always_comb begin
      if (!en)          lvl = live_t.idle_lvl;
      else if (phase_q) lvl = sh_t.busy_lvl;
      else              lvl = sh_t.idle_lvl;
   end

   assign pwm_oe  = lvl[1];
   assign pwm_out = lvl[1] & lvl[0];

   // R5: the running count never passes the period in force
   p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> (cnt_q <= sh_t.span));

   // R8: the shadow copy only changes at a wrap while running
   p_shadow_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !(tick && wrap)) |=> ($stable(sh_t) && $stable(sh_e)));

   // R7: with a divider above one, ticks are never back to back inside a period
   p_tick_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wrap && sh_t.div_sel != 3'd0) |=> !tick);

   // R9: a stopped channel has its counter at zero
   p_cnt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (cnt_q == '0));

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
   import pwm_bank_pkg::*;
#(
   parameter int NUM_CHANNELS = 8,
   parameter int ADDR_W       = 12
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bus_sel,
   input  logic                    bus_we,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic [31:0]             bus_wdata,
   output logic [31:0]             bus_rdata,
   output logic [NUM_CHANNELS-1:0] pwm_out,
   output logic [NUM_CHANNELS-1:0] pwm_oe
);

   if (NUM_CHANNELS < 1 || NUM_CHANNELS > 16) begin : g_bad_count
      $error("pwm_bank: NUM_CHANNELS must be 1..16");
   end
   if (ADDR_W < 5 || (2 * NUM_CHANNELS + 1) > (1 << (ADDR_W - 4))) begin : g_bad_addr
      $error("pwm_bank: ADDR_W too small for the register map");
   end

   logic [NUM_CHANNELS-1:0]       run_en;
   logic [NUM_CHANNELS-1:0][31:0] edge_cfg;
   logic [NUM_CHANNELS-1:0][31:0] time_cfg;

   pwm_bank_regfile #(
      .NUM_CHANNELS (NUM_CHANNELS),
      .ADDR_W       (ADDR_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .run_en    (run_en),
      .edge_cfg  (edge_cfg),
      .time_cfg  (time_cfg)
   );

   for (genvar n = 0; n < NUM_CHANNELS; n++) begin : g_chan
      pwm_bank_channel u_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .en        (run_en[n]),
         .edge_live (edge_cfg[n]),
         .time_live (time_cfg[n]),
         .pwm_out   (pwm_out[n]),
         .pwm_oe    (pwm_oe[n])
      );
   end

endmodule

// File: tb/pwm_bank_bench.sv
`timescale 1ns/1ps
module pwm_bank_bench;

   localparam int NCH = 8;
   localparam int AW  = 12;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           bus_sel = 1'b0;
   logic           bus_we = 1'b0;
   logic [AW-1:0]  bus_addr = '0;
   logic [31:0]    bus_wdata = '0;
   logic [31:0]    bus_rdata;
   logic [NCH-1:0] pwm_out;
   logic [NCH-1:0] pwm_oe;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pwm_bank #(.NUM_CHANNELS(NCH), .ADDR_W(AW)) u_pwm_bank (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pwm_out(pwm_out), .pwm_oe(pwm_oe)
   );

   function automatic logic [AW-1:0] edge_addr(int ch);
      return AW'(32'h10 + 32 * ch);
   endfunction
   function automatic logic [AW-1:0] time_addr(int ch);
      return AW'(32'h20 + 32 * ch);
   endfunction
   function automatic int div_of(int idx);
      return (idx < 5) ? (1 << idx) : (1 << (2 * idx - 4));
   endfunction
   function automatic logic [31:0] time_word(int p, int idx, int al, int il);
      return (32'(idx) << 20) | (32'(il) << 18) | (32'(al) << 16) | 32'(p);
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(logic [AW-1:0] a, logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic bus_read(logic [AW-1:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic setup(int ch, int a, int b, int p, int idx, int al, int il);
      bus_write(edge_addr(ch), (32'(b) << 16) | 32'(a));
      bus_write(time_addr(ch), time_word(p, idx, al, il));
   endtask

   // expected level code for cycle k after enable, constant settings
   function automatic int exp_code(int k, int a, int b, int p, int idx, int al, int il);
      int c;
      c = (k / div_of(idx)) % (p + 1);
      return ((a <= c) && (c < b)) ? al : il;
   endfunction

   // compares cycle by cycle from the first cycle after enable
   task automatic wave(string req, int ch, int a, int b, int p, int idx, int al, int il, int ncyc);
      int bad = 0;
      logic [1:0] first_act = '0, first_exp = '0;
      for (int k = 0; k < ncyc; k++) begin
         int code;
         code = exp_code(k, a, b, p, idx, al, il);
         if ({pwm_oe[ch], pwm_out[ch]} !== {code[1], code == 3}) begin
            if (bad == 0) begin
               first_act = {pwm_oe[ch], pwm_out[ch]};
               first_exp = {code[1], code == 3};
               $display("  mismatch %s ch%0d at cycle %0d", req, ch, k);
            end
            bad++;
         end
         @(negedge clk);
      end
      check(req, (bad == 0) ? 32'(first_exp) : 32'(first_act), 32'(first_exp));
   endtask

   task automatic t_reset();
      logic [31:0] d;
      check("R1 oe after reset", 32'(pwm_oe), 32'h0);
      bus_read(12'h000, d); check("R1 enable reg reset", d, 32'h0);
      bus_read(time_addr(7), d); check("R1 timing reg reset", d, 32'h0);
      bus_read(edge_addr(3), d); check("R1 edge reg reset", d, 32'h0);
   endtask

   task automatic t_regs();
      logic [31:0] d;
      for (int ch = 0; ch < NCH; ch++) bus_write(time_addr(ch), 32'h0000_0100 + 32'(ch));
      for (int ch = 0; ch < NCH; ch++) bus_write(edge_addr(ch), 32'hE000_0000 + 32'(ch));
      for (int ch = 0; ch < NCH; ch++) begin
         bus_read(time_addr(ch), d); check("R4 timing reg map", d, 32'h0000_0100 + 32'(ch));
         bus_read(edge_addr(ch), d); check("R4 edge reg map", d, 32'hE000_0000 + 32'(ch));
      end
      bus_write(time_addr(7), 32'hFFFF_FFFF);
      bus_read(time_addr(7), d); check("R2 timing reserved bits", d, 32'h007F_FFFF);
      bus_write(time_addr(7), 32'h0);
      bus_write(edge_addr(7), 32'hA5A5_5A5A);
      bus_read(edge_addr(7), d); check("R2 edge full word", d, 32'hA5A5_5A5A);
      bus_read(12'h110, d); check("R2 unmapped slot", d, 32'h0);
      bus_read(12'h800, d); check("R2 unmapped high", d, 32'h0);
      bus_write(12'h000, 32'hFFFF_FFFF);
      bus_read(12'h000, d); check("R2 enable reg width", d, 32'h0000_00FF);
      bus_write(12'h000, 32'h0);
      for (int ch = 0; ch < NCH; ch++) bus_write(time_addr(ch), 32'h0);
   endtask

   task automatic t_alias();
      logic [31:0] d;
      bus_write(12'h000, 32'h0F);
      bus_write(12'h004, 32'h30);
      bus_read(12'h000, d); check("R3 set alias", d, 32'h3F);
      bus_write(12'h008, 32'h05);
      bus_read(12'h000, d); check("R3 clear alias", d, 32'h3A);
      bus_write(12'h00C, 32'hFF);
      bus_read(12'h000, d); check("R3 toggle alias", d, 32'hC5);
      bus_write(12'h000, 32'h0);
      bus_write(edge_addr(1), 32'h1234_5678);
      bus_write(edge_addr(1) | 12'hC, 32'hFFFF_0000);
      bus_read(edge_addr(1), d); check("R3 toggle on edge reg", d, 32'hEDCB_5678);
      bus_write(time_addr(0), 32'h0);
      bus_write(time_addr(0) | 12'h4, 32'h0030_0000);
      bus_write(time_addr(0) | 12'h8, 32'h0010_0000);
      bus_read(time_addr(0), d); check("R3 set then clear on timing reg", d, 32'h0020_0000);
      bus_write(time_addr(0), 32'h0);
      bus_write(edge_addr(1), 32'h0);
   endtask

   task automatic t_wave();
      bus_write(12'h000, 32'h0);
      setup(2, 0, 3, 7, 0, 3, 2);
      bus_write(12'h004, 32'h04);
      wave("R5 duty from count 0", 2, 0, 3, 7, 0, 3, 2, 26);
      bus_write(12'h008, 32'h04);
      setup(2, 2, 6, 9, 0, 2, 3);
      bus_write(12'h004, 32'h04);
      wave("R6 inverted levels mid-period pulse", 2, 2, 6, 9, 0, 2, 3, 33);
      bus_write(12'h008, 32'h04);
      setup(2, 3, 3, 6, 0, 3, 2);
      bus_write(12'h004, 32'h04);
      wave("R5 equal edges fall wins", 2, 3, 3, 6, 0, 3, 2, 16);
      bus_write(12'h008, 32'h04);
      setup(2, 0, 20, 4, 0, 3, 2);
      bus_write(12'h004, 32'h04);
      wave("R5 fall beyond period full duty", 2, 0, 20, 4, 0, 3, 2, 16);
      bus_write(12'h008, 32'h04);
      setup(2, 0, 2, 3, 0, 1, 0);
      bus_write(12'h004, 32'h04);
      wave("R6 released levels", 2, 0, 2, 3, 0, 1, 0, 10);
      bus_write(12'h008, 32'h04);
   endtask

   task automatic t_div();
      for (int idx = 0; idx < 8; idx++) begin
         bus_write(12'h000, 32'h0);
         setup(1, 0, 1, 1, idx, 3, 2);
         bus_write(12'h004, 32'h02);
         wave($sformatf("R7 divider index %0d", idx), 1, 0, 1, 1, idx, 3, 2, 4 * div_of(idx) + 2);
      end
      bus_write(12'h000, 32'h0);
   endtask

   task automatic t_shadow();
      int bad = 0;
      bus_write(12'h000, 32'h0);
      setup(4, 0, 5, 9, 0, 3, 2);
      bus_write(12'h004, 32'h10);
      for (int k = 0; k < 30; k++) begin
         int code;
         code = (k < 10) ? exp_code(k, 0, 5, 9, 0, 3, 2) : exp_code(k - 10, 0, 2, 3, 0, 3, 2);
         if ({pwm_oe[4], pwm_out[4]} !== {code[1], code == 3}) begin
            if (bad == 0) $display("  mismatch R8 at cycle %0d", k);
            bad++;
         end
         if (k == 3) begin
            bus_sel = 1'b1; bus_we = 1'b1; bus_addr = time_addr(4); bus_wdata = time_word(3, 0, 3, 2);
         end else if (k == 4) begin
            bus_addr = edge_addr(4); bus_wdata = 32'h0002_0000;
         end else if (k == 5) begin
            bus_sel = 1'b0; bus_we = 1'b0;
         end
         @(negedge clk);
      end
      check("R8 update waits for wrap (mismatched cycles)", 32'(bad), 32'h0);
      bus_write(12'h000, 32'h0);
   endtask

   task automatic t_disable();
      bus_write(12'h000, 32'h0);
      setup(3, 0, 2, 5, 0, 2, 3);
      bus_write(12'h004, 32'h08);
      wave("R9 run before stop", 3, 0, 2, 5, 0, 2, 3, 9);
      bus_write(12'h008, 32'h08);
      check("R9 stopped shows idle level", {30'h0, pwm_oe[3], pwm_out[3]}, 32'h3);
      bus_write(time_addr(3), time_word(5, 0, 2, 0));
      check("R9 stopped follows live idle level", {30'h0, pwm_oe[3], pwm_out[3]}, 32'h0);
      bus_write(time_addr(3), time_word(5, 0, 2, 3));
      repeat (3) @(negedge clk);
      bus_write(12'h004, 32'h08);
      wave("R9 restart from zero", 3, 0, 2, 5, 0, 2, 3, 20);
      bus_write(12'h000, 32'h0);
   endtask

   task automatic t_indep();
      bus_write(12'h000, 32'h0);
      setup(0, 0, 0, 3, 0, 2, 3);
      setup(6, 0, 2, 4, 1, 3, 2);
      bus_write(12'h004, 32'h41);
      wave("R4 channel 6 alongside channel 0", 6, 0, 2, 4, 1, 3, 2, 25);
      check("R4 channel 0 steady idle high", {30'h0, pwm_oe[0], pwm_out[0]}, 32'h3);
      bus_write(12'h008, 32'h40);
      check("R4 clearing bit 6 leaves bit 0", {30'h0, pwm_oe[0], pwm_out[0]}, 32'h3);
      bus_write(12'h000, 32'h0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_alias();
      t_wave();
      t_div();
      t_shadow();
      t_disable();
      t_indep();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule